// File: doc/BRIEF.md
# Polled ADC Conversion Sequencer

This block drives an external successive-approximation converter that has one start-conversion line and one status line. The status line is high while a conversion runs. Software loads a start-pulse width, a sample period, a timeout and a sample count, then pulses `rec_start`. For each sample, the sequencer raises `adc_convst` for the programmed width. It then polls the synchronized status until the converter has signalled busy and has come out of busy again. At that point it keeps the nine most significant of the twelve result bits and writes them into the next slot of an internal capture buffer. The next conversion starts only after the current one has ended and the sample period has elapsed.

When the programmed number of samples is stored, the record ends and `rec_done` is raised. If the converter does not finish within the timeout, the record is aborted and `rec_err` is raised. Both flags hold until the next accepted start. The captured record is read back through a synchronous read port. With a 100 MHz clock, a period of about 926 cycles gives the intended rate of roughly 108 thousand samples per second, which is enough for a 40 kHz echo.

Top module: `adc_poll_seq`

## Requirements
- R1: After reset, `adc_convst`, `rec_busy`, `rec_done` and `rec_err` are all low.
- R2: A `rec_start` seen at a clock edge while idle makes `rec_busy` high and `adc_convst` high in the cycle after that edge. It also clears `rec_done` and `rec_err`.
- R3: Each start pulse stays high for exactly `cfg_pulse_len` clock cycles. A value of 0 gives one cycle. `adc_convst` is high only while `rec_busy` is high.
- R4: The status passes through a two-flop synchronizer. A sample is taken only after the synchronized status has been seen high and then low. A result presented while the status is still high is never stored.
- R5: Each stored sample equals bits [11:3] of `adc_data`, the nine most significant bits of the result.
- R6: Rising edges of `adc_convst` within a record are exactly `cfg_period` cycles apart when the conversion ends early enough. When a conversion takes longer, the next start waits for its end, so the spacing then exceeds the conversion time.
- R7: Sample n of a record is written at buffer address n, for n from 0 to `cfg_count`-1. `rd_data` shows the entry at `rd_addr` one clock after `rd_addr` is applied.
- R8: After `cfg_count` samples, `rec_busy` falls and `rec_done` rises in the same cycle, and no further start pulse follows. `rec_done` stays high until the next accepted start. A count of 0 is treated as 1, and a count above the depth is treated as the depth.
- R9: If the status does not complete the high-then-low sequence within `cfg_timeout` cycles after a start pulse ends, the record stops, `rec_err` rises and stays high until the next accepted start, and `rec_done` stays low. No further start pulse is issued, and the buffer entry for that sample is left unchanged.
- R10: `rec_start` while `rec_busy` is high is ignored. The record goes on with the same number of conversions and the same stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pulse_len | input | CNT_W | Start-pulse width in cycles (0 means 1) |
| cfg_period | input | CNT_W | Minimum cycles between start pulses |
| cfg_timeout | input | CNT_W | Cycles allowed for the status handshake after a pulse |
| cfg_count | input | IDX_W+1 | Samples per record |
| rec_start | input | 1 | Start a record (ignored while busy) |
| adc_convst | output | 1 | Start-conversion line to the converter |
| adc_busy | input | 1 | Converter status, high while converting, asynchronous |
| adc_data | input | RAW_W | Converter result bus |
| rec_busy | output | 1 | Record in progress |
| rec_done | output | 1 | Sticky: record completed |
| rec_err | output | 1 | Sticky: record aborted on timeout |
| rd_addr | input | IDX_W | Capture buffer read address |
| rd_data | output | KEEP_W | Capture buffer read data, one cycle latency |

## Verification
The hardest situation to reach from the ports is a handshake that never completes, in either of its two forms. In one, the converter never shows busy. In the other, the status stays busy forever. The bench's converter model has a mode for each. Each mode is run right after a good record with a different data offset. This shows that the abort leaves the old buffer entry in place, that no second pulse appears, and that the next good record clears the error. Sampling only after the end of conversion is exposed by having the model drive a wrong value while busy, so an early read shows up as a data mismatch.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the polled converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;

    // Phases of one record, one conversion at a time.
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_PULSE   = 3'd1,
        SQ_WAIT_HI = 3'd2,
        SQ_WAIT_LO = 3'd3,
        SQ_GAP     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/adc_status_sync.sv
// Module: multi-stage synchronizer for the asynchronous converter status.
// Assumes: the input toggles slower than the clock; STAGES >= 2.
module adc_status_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the status through the flop chain; reset to idle (not busy).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/adc_capture_buf.sv
// Module: single-write, single-read capture memory with a registered read.
// Assumes: write and read may hit the same address; read returns old data then.
module adc_capture_buf #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WIDTH  = 9,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one sample when the sequencer asks.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: record controller. Issues start pulses, polls the synchronized
// status for a high-then-low handshake, writes truncated results and
// paces conversions by a period counter.
// Assumes: status input is already synchronized; result is stable once the
// status has returned low and until the next start pulse.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned KEEP_W = 9,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_pulse_len,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic [IDX_W:0]    cfg_count,
    input  logic              rec_start,
    input  logic              busy_s,
    input  logic [KEEP_W-1:0] sample_in,
    output logic              convst,
    output logic              rec_busy,
    output logic              rec_done,
    output logic              rec_err,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [KEEP_W-1:0] wr_data
);

    localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

    seq_state_t        state;
    logic [CNT_W-1:0]  per_cnt;
    logic [CNT_W-1:0]  ph_cnt;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  pulse_eff;
    logic [IDX_W:0]    count_eff;
    logic [IDX_W:0]    last_idx;
    logic              eoc_seen;
    logic              timed_out;

    // Clamp the programmed pulse width and sample count to legal values.
    always_comb begin
        pulse_eff = (cfg_pulse_len == '0) ? CNT_W'(1) : cfg_pulse_len;
        if (cfg_count == '0) begin
            count_eff = (IDX_W+1)'(1);
        end else if (cfg_count > DEPTH_V) begin
            count_eff = DEPTH_V;
        end else begin
            count_eff = cfg_count;
        end
        last_idx  = count_eff - 1'b1;
        eoc_seen  = (state == SQ_WAIT_LO) && !busy_s;
        timed_out = (ph_cnt >= cfg_timeout);
    end

    // Main sequencing, counters and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            per_cnt  <= '0;
            ph_cnt   <= '0;
            idx      <= '0;
            rec_done <= 1'b0;
            rec_err  <= 1'b0;
        end else begin
            if (per_cnt != '1) begin
                per_cnt <= per_cnt + 1'b1;
            end
            unique case (state)
                SQ_IDLE: begin
                    if (rec_start) begin
                        state    <= SQ_PULSE;
                        per_cnt  <= CNT_W'(1);
                        ph_cnt   <= CNT_W'(1);
                        idx      <= '0;
                        rec_done <= 1'b0;
                        rec_err  <= 1'b0;
                    end
                end
                SQ_PULSE: begin
                    if (ph_cnt >= pulse_eff) begin
                        state  <= SQ_WAIT_HI;
                        ph_cnt <= '0;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SQ_WAIT_HI: begin
                    if (busy_s) begin
                        state  <= SQ_WAIT_LO;
                        ph_cnt <= ph_cnt + 1'b1;
                    end else if (timed_out) begin
                        state   <= SQ_IDLE;
                        rec_err <= 1'b1;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SQ_WAIT_LO: begin
                    if (!busy_s) begin
                        if ({1'b0, idx} == last_idx) begin
                            state    <= SQ_IDLE;
                            rec_done <= 1'b1;
                        end else begin
                            state <= SQ_GAP;
                            idx   <= idx + 1'b1;
                        end
                    end else if (timed_out) begin
                        state   <= SQ_IDLE;
                        rec_err <= 1'b1;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (per_cnt >= cfg_period) begin
                        state   <= SQ_PULSE;
                        per_cnt <= CNT_W'(1);
                        ph_cnt  <= CNT_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Port-facing decodes of the state.
    assign convst   = (state == SQ_PULSE);
    assign rec_busy = (state != SQ_IDLE);
    assign wr_en    = eoc_seen;
    assign wr_addr  = idx;
    assign wr_data  = sample_in;

endmodule

// File: rtl/adc_poll_seq.sv
// Module: top of the polled converter sequencer. Synchronizes the status,
// runs the record controller and holds the captured samples.
// Assumes: adc_busy is asynchronous, high while a conversion runs.
module adc_poll_seq #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned RAW_W  = 12,
    parameter int unsigned KEEP_W = 9,
    parameter int unsigned SYNC_N = 2,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_pulse_len,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic [IDX_W:0]    cfg_count,
    input  logic              rec_start,
    output logic              adc_convst,
    input  logic              adc_busy,
    input  logic [RAW_W-1:0]  adc_data,
    output logic              rec_busy,
    output logic              rec_done,
    output logic              rec_err,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [KEEP_W-1:0] rd_data
);

    localparam int unsigned DROP_W = RAW_W - KEEP_W;

    logic              busy_s;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic [KEEP_W-1:0] wr_data;
    logic [KEEP_W-1:0] kept_bits;
    logic              unused_low_bits;

    // Keep the most significant bits; the rest are discarded as noise.
    assign kept_bits       = adc_data[RAW_W-1 -: KEEP_W];
    assign unused_low_bits = ^adc_data[DROP_W-1:0];

    adc_status_sync #(
        .STAGES  (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (adc_busy),
        .sync_out (busy_s)
    );

    adc_seq_ctrl #(
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .KEEP_W (KEEP_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_pulse_len (cfg_pulse_len),
        .cfg_period    (cfg_period),
        .cfg_timeout   (cfg_timeout),
        .cfg_count     (cfg_count),
        .rec_start     (rec_start),
        .busy_s        (busy_s),
        .sample_in     (kept_bits),
        .convst        (adc_convst),
        .rec_busy      (rec_busy),
        .rec_done      (rec_done),
        .rec_err       (rec_err),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data)
    );

    adc_capture_buf #(
        .DEPTH (DEPTH),
        .WIDTH (KEEP_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/adc_seq_checker.sv
// Module: protocol checks for the sequencer, attached by bind.
// Assumes: reset is held low from time zero.
module adc_seq_checker #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_convst,
    input logic             rec_busy,
    input logic             rec_done,
    input logic             rec_err,
    input logic             rec_start,
    input logic             busy_s,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_addr,
    input logic [IDX_W:0]   cfg_count
);

    // Start pulses only inside a record.
    p_convst_in_record_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> rec_busy);

    // A sample is written only once the synchronized status is low.
    p_write_after_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy_s);

    // Writes stay inside the programmed record and inside a record.
    p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_count != '0) |-> ({1'b0, wr_addr} < cfg_count));

    p_write_in_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rec_busy);

    // Completion ends the record in the same cycle.
    p_done_ends_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_done) |-> (!rec_busy && $past(rec_busy)));

    // Done is sticky until a new start.
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && !rec_start) |=> rec_done);

    // Error is sticky until a new start and never coexists with done.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_err && !rec_start) |=> rec_err);

    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_done && rec_err));

    // A start during a record does not restart the flags.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_busy && rec_start) |=> (rec_busy || rec_done || rec_err));

endmodule

bind adc_poll_seq adc_seq_checker #(
    .IDX_W (IDX_W)
) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_convst (adc_convst),
    .rec_busy   (rec_busy),
    .rec_done   (rec_done),
    .rec_err    (rec_err),
    .rec_start  (rec_start),
    .busy_s     (busy_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cfg_count  (cfg_count)
);

// File: tb/test_adc_poll_seq.sv
// Bench: directed scenarios, one task each, with a converter model.
module test_adc_poll_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int DEPTH  = 64;
    localparam int RAW_W  = 12;
    localparam int KEEP_W = 9;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_pulse_len = '0;
    logic [CNT_W-1:0]  cfg_period = '0;
    logic [CNT_W-1:0]  cfg_timeout = '0;
    logic [IDX_W:0]    cfg_count = '0;
    logic              rec_start = 1'b0;
    logic              adc_convst;
    logic              adc_busy = 1'b0;
    logic [RAW_W-1:0]  adc_data = '1;
    logic              rec_busy;
    logic              rec_done;
    logic              rec_err;
    logic [IDX_W-1:0]  rd_addr = '0;
    logic [KEEP_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Monitor state
    int  rise_cnt, min_gap, max_gap, min_w, max_w, hi_w, last_rise;
    logic mon_prev = 1'b0;

    // Converter model state
    int  m_mode = 0;   // 0 normal, 1 never busy, 2 stuck busy
    int  m_lat  = 6;
    int  m_idx  = 0;
    int  m_base = 0;
    int  m_cnt  = 0;
    logic m_prev = 1'b0;

    adc_poll_seq #(
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .RAW_W  (RAW_W),
        .KEEP_W (KEEP_W)
    ) i_adc_poll_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_pulse_len (cfg_pulse_len),
        .cfg_period    (cfg_period),
        .cfg_timeout   (cfg_timeout),
        .cfg_count     (cfg_count),
        .rec_start     (rec_start),
        .adc_convst    (adc_convst),
        .adc_busy      (adc_busy),
        .adc_data      (adc_data),
        .rec_busy      (rec_busy),
        .rec_done      (rec_done),
        .rec_err       (rec_err),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [RAW_W-1:0] sample_val(int k);
        return RAW_W'(k * 421 + 165);
    endfunction

    // Converter model: busy on start, result valid only when busy drops.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_cnt    = 0;
            adc_busy = 1'b0;
        end else begin
            if (m_cnt == 0 && m_mode == 0) adc_busy = 1'b0;
            if (adc_convst && !m_prev && m_cnt == 0) begin
                m_cnt = m_lat;
                adc_data = '1;
                if (m_mode != 1) adc_busy = 1'b1;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0 && m_mode == 0) begin
                    adc_busy = 1'b0;
                    adc_data = sample_val(m_idx + m_base);
                    m_idx++;
                end
            end
        end
        m_prev = adc_convst;
    end

    // Start-pulse monitor: spacing and width of adc_convst.
    always @(negedge clk) begin
        if (adc_convst && !mon_prev) begin
            rise_cnt++;
            if (rise_cnt > 1) begin
                if (cyc - last_rise < min_gap) min_gap = cyc - last_rise;
                if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
            end
            last_rise = cyc;
            hi_w = 1;
        end else if (adc_convst) begin
            hi_w++;
        end
        if (!adc_convst && mon_prev) begin
            if (hi_w < min_w) min_w = hi_w;
            if (hi_w > max_w) max_w = hi_w;
        end
        mon_prev = adc_convst;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        rise_cnt = 0; min_gap = 1000000; max_gap = 0;
        min_w = 1000000; max_w = 0; hi_w = 0; last_rise = 0;
    endtask

    task automatic config_run(input int cnt, input int per, input int pw,
                              input int tmo, input int lat, input int mode,
                              input int base);
        cfg_count     = (IDX_W+1)'(cnt);
        cfg_period    = CNT_W'(per);
        cfg_pulse_len = CNT_W'(pw);
        cfg_timeout   = CNT_W'(tmo);
        m_lat = lat; m_mode = mode; m_base = base; m_idx = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!rec_busy) break;
        end
    endtask

    task automatic check_buf(input int cnt, input int base, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            rd_addr = IDX_W'(i);
            @(negedge clk);
            if (rd_data != sample_val(i + base) >> (RAW_W - KEEP_W)) begin
                if (bad == 0)
                    chk(1'b0, req, $sformatf("buffer entry %0d", i),
                        int'(rd_data), int'(sample_val(i + base) >> (RAW_W - KEEP_W)));
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, req, "buffer contents", 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(adc_convst == 1'b0, "R1", "convst after reset", int'(adc_convst), 0);
        chk(rec_busy == 1'b0,   "R1", "busy after reset",   int'(rec_busy), 0);
        chk(rec_done == 1'b0,   "R1", "done after reset",   int'(rec_done), 0);
        chk(rec_err == 1'b0,    "R1", "err after reset",    int'(rec_err), 0);
    endtask

    // Fast conversions: exact spacing, width, truncated data, done.
    task automatic t_basic();
        config_run(8, 20, 3, 100, 6, 0, 0);
        clear_mon();
        @(negedge clk); rec_start = 1'b1;
        @(negedge clk); rec_start = 1'b0;
        chk(rec_busy == 1'b1 && adc_convst == 1'b1, "R2", "busy and convst after start",
            int'({rec_busy, adc_convst}), 3);
        wait_idle(1000);
        chk(rec_done == 1'b1 && rec_err == 1'b0, "R8", "done after record",
            int'({rec_done, rec_err}), 2);
        chk(rise_cnt == 8, "R8", "start pulse count", rise_cnt, 8);
        chk(min_gap == 20 && max_gap == 20, "R6", "exact spacing", min_gap, 20);
        chk(min_w == 3 && max_w == 3, "R3", "pulse width", max_w, 3);
        check_buf(8, 0, "R5");
        repeat (30) @(negedge clk);
        chk(rec_done == 1'b1 && rise_cnt == 8, "R8", "done sticky, no extra pulse",
            rise_cnt, 8);
    endtask

    // Slow conversions: start waits for end; data read after end only.
    task automatic t_slow();
        config_run(4, 20, 2, 100, 30, 0, 7);
        clear_mon();
        pulse_start();
        chk(rec_done == 1'b0, "R2", "done cleared by start", int'(rec_done), 0);
        wait_idle(1000);
        chk(min_gap > 30 && min_gap >= 20, "R6", "spacing follows slow conversion",
            min_gap, 31);
        check_buf(4, 7, "R4");
    endtask

    // Zero pulse width gives a single-cycle pulse; zero count gives one sample.
    task automatic t_pulse_zero();
        config_run(0, 10, 0, 100, 4, 0, 50);
        clear_mon();
        pulse_start();
        wait_idle(1000);
        chk(min_w == 1 && max_w == 1, "R3", "zero width gives one cycle", max_w, 1);
        chk(rise_cnt == 1 && rec_done == 1'b1, "R8", "count zero treated as one",
            rise_cnt, 1);
    endtask

    // Start while busy is ignored.
    task automatic t_ignore_start();
        config_run(6, 25, 3, 100, 8, 0, 13);
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        repeat (20) @(negedge clk);
        rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        wait_idle(2000);
        chk(rise_cnt == 6, "R10", "pulse count with extra start", rise_cnt, 6);
        chk(min_gap == 25 && max_gap == 25, "R10", "spacing undisturbed", max_gap, 25);
        chk(m_idx == 6 && rec_done == 1'b1, "R10", "conversions completed", m_idx, 6);
        check_buf(6, 13, "R10");
    endtask

    // Full-depth record: last address written.
    task automatic t_full();
        config_run(DEPTH, 12, 2, 100, 4, 0, 100);
        clear_mon();
        pulse_start();
        wait_idle(5000);
        chk(rise_cnt == DEPTH && rec_done == 1'b1, "R7", "full record pulses",
            rise_cnt, DEPTH);
        check_buf(DEPTH, 100, "R7");
    endtask

    // Handshake failures: never busy, then stuck busy.
    task automatic t_timeout(input int mode, input int base_old);
        config_run(4, 20, 3, 100, 6, 0, base_old);
        clear_mon();
        pulse_start();
        wait_idle(1000);
        config_run(4, 20, 3, 40, 6, mode, base_old + 50);
        clear_mon();
        pulse_start();
        wait_idle(1000);
        chk(rec_err == 1'b1 && rec_done == 1'b0 && rec_busy == 1'b0, "R9",
            $sformatf("timeout flags mode %0d", mode), int'({rec_err, rec_done, rec_busy}), 4);
        repeat (100) @(negedge clk);
        chk(rise_cnt == 1, "R9", "no pulse after abort", rise_cnt, 1);
        chk(rec_err == 1'b1, "R9", "error sticky", int'(rec_err), 1);
        check_buf(1, base_old, "R9");
        config_run(2, 20, 3, 100, 6, 0, 3);
        @(negedge clk); rec_start = 1'b1;
        @(negedge clk); rec_start = 1'b0;
        chk(rec_err == 1'b0 && rec_busy == 1'b1, "R9", "error cleared by new start",
            int'(rec_err), 0);
        wait_idle(1000);
        chk(rec_done == 1'b1, "R8", "record after error completes", int'(rec_done), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_slow();
        t_pulse_zero();
        t_ignore_start();
        t_full();
        t_timeout(1, 200);
        t_timeout(2, 300);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule